// File: doc/BRIEF.md
# Banked Scratchpad with XOR Swizzle

This block is an on-chip scratchpad that holds 2D tiles in 32 banks of 32-bit words. Each cycle it can take one request from 32 lanes, where every lane carries a byte address within the tile. A request is either all reads or all writes. Each address is split into a row, which is the 128-byte line of the tile, and a word index within that row. The word index picks the bank and the row picks the word inside the bank. When the request's swizzle bit is set, the word index is first XORed with the low bits of the row. A column walk down a power-of-two-wide tile then spreads across all banks, with no padding needed.

When several active lanes need different words from one bank, the request is split into passes. In each pass a bank serves one word, and every pending lane that wants that word is served in the same pass. The block raises a stall output while passes remain. At the end it reports the number of passes it used. Read data for every lane comes back together when the request ends.

Top module: `xor_scratchpad`

## Requirements
- R1: Linear mapping. With the swizzle bit clear, bank = byte address bits [6:2] and the word inside the bank = bits [12:7], which is the row. Two lanes 128 bytes apart need two passes. Two lanes 4 bytes apart need one pass.
- R2: A request whose active lanes all use distinct banks finishes in one pass. `done` is high in the cycle after acceptance, `pass_cnt` = 1, and `stall` never rises.
- R3: The pass count equals the largest number of distinct words requested in any single bank. A request with 32 lanes on one bank at 32 different rows takes 32 passes.
- R4: Lanes that ask for the same word of the same bank share one pass, and they all receive that word.
- R5: With the swizzle bit set, the in-row word index is replaced by word XOR row[4:0]. A 32-row column read of one word index takes 1 pass when swizzled and 32 passes when linear. Data written at swizzled (r, w) can be read linearly at (r, w XOR r[4:0]).
- R6: Because the XOR mapping is its own inverse, writing and then reading in the same mode returns the written data. This holds in both modes.
- R7: `stall` is high from the cycle after a multi-pass request is accepted until its final pass. Requests presented while `stall` is high are ignored and write nothing.
- R8: All read data appears together on `rd_data` (lane l at bits [32l+31:32l]) in the cycle `done` is high. Lanes whose enable was low read as zero.
- R9: When several lanes write the same word, the lowest-numbered lane's data is stored.
- R10: A request with no enabled lane completes with `done` high one cycle later and `pass_cnt` = 0.
- R11: After reset, `stall`, `done` and `pass_cnt` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; accepted when `stall` is low |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_swz | input | 1 | Apply the XOR swizzle to this request |
| lane_en | input | 32 | Per-lane enable |
| lane_addr | input | 416 | 32 byte addresses of 13 bits each, lane l at [13l+12:13l] |
| lane_wdata | input | 1024 | Write data, lane l at [32l+31:32l] |
| stall | output | 1 | Multi-pass request in progress; new requests are held off |
| done | output | 1 | One-cycle pulse when a request ends |
| rd_data | output | 1024 | Read data of all lanes, valid with `done` |
| pass_cnt | output | 6 | Number of passes used by the request that just ended |

## Verification
The assertions assume that the environment keeps `req_valid` low, or does not care about it, while `stall` is high. They also assume that the two low address bits are zero and that every row index fits the tile depth. The stimulus generates all addresses from a row and a word index, so the alignment and depth assumptions always hold. It drives new requests only after the previous `done` pulse. The single deliberate exception is a request presented under `stall`, which is there to show that such a request is dropped.

// File: rtl/xor_scratchpad.sv
module xor_scratchpad #(
  parameter int LANES = 32,
  parameter int BANKS = 32,
  parameter int ROW_W = 6,
  parameter int DW    = 32,
  parameter int AW    = ROW_W + $clog2(BANKS) + 2,
  parameter int CW    = $clog2(LANES + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic                req_swz,
  input  logic [LANES-1:0]    lane_en,
  input  logic [LANES*AW-1:0] lane_addr,
  input  logic [LANES*DW-1:0] lane_wdata,
  output logic                stall,
  output logic                done,
  output logic [LANES*DW-1:0] rd_data,
  output logic [CW-1:0]       pass_cnt
);
  localparam int BW    = $clog2(BANKS);
  localparam int LW    = $clog2(LANES);
  localparam int DEPTH = 1 << ROW_W;

  logic [DW-1:0]    mem [BANKS][DEPTH];
  logic [LANES-1:0] pend_q, cur_pend, serve, left;
  logic [BW-1:0]    in_bank [LANES], bank_q [LANES], cur_bank [LANES];
  logic [ROW_W-1:0] in_row [LANES], off_q [LANES], cur_off [LANES];
  logic [DW-1:0]    wd_q [LANES], cur_wd [LANES], rd_q [LANES];
  logic [BANKS-1:0] found;
  logic [LW-1:0]    lead [BANKS];
  logic             wr_q, cur_wr, accept;
  logic [CW-1:0]    cnt_q, cnt_run;

  assign accept   = req_valid && !stall;
  assign cur_wr   = stall ? wr_q : req_write;
  assign cur_pend = stall ? pend_q : (req_valid ? lane_en : '0);
  assign cnt_run  = stall ? cnt_q + 1'b1 : CW'(1);
  assign left     = cur_pend & ~serve;

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      in_row[l]  = lane_addr[l*AW + BW + 2 +: ROW_W];
      in_bank[l] = lane_addr[l*AW + 2 +: BW] ^ (req_swz ? in_row[l][BW-1:0] : '0);
      cur_bank[l] = stall ? bank_q[l] : in_bank[l];
      cur_off[l]  = stall ? off_q[l]  : in_row[l];
      cur_wd[l]   = stall ? wd_q[l]   : lane_wdata[l*DW +: DW];
    end
  end

  always_comb begin
    found = '0;
    for (int b = 0; b < BANKS; b++) begin
      lead[b] = '0;
      for (int l = LANES - 1; l >= 0; l--)
        if (cur_pend[l] && cur_bank[l] == BW'(b)) begin
          found[b] = 1'b1;
          lead[b]  = LW'(l);
        end
    end
    for (int l = 0; l < LANES; l++)
      serve[l] = cur_pend[l] && (cur_off[l] == cur_off[lead[cur_bank[l]]]);
  end

  always_ff @(posedge clk) begin
    for (int b = 0; b < BANKS; b++)
      if (cur_wr && found[b])
        mem[b][cur_off[lead[b]]] <= cur_wd[lead[b]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stall    <= 1'b0;
      done     <= 1'b0;
      pass_cnt <= '0;
      pend_q   <= '0;
      cnt_q    <= '0;
      wr_q     <= 1'b0;
      for (int l = 0; l < LANES; l++) rd_q[l] <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        wr_q <= req_write;
        for (int l = 0; l < LANES; l++) begin
          bank_q[l] <= in_bank[l];
          off_q[l]  <= in_row[l];
          wd_q[l]   <= lane_wdata[l*DW +: DW];
          if (!req_write) rd_q[l] <= '0;
        end
      end
      if (|cur_pend) begin
        for (int l = 0; l < LANES; l++)
          if (serve[l] && !cur_wr) rd_q[l] <= mem[cur_bank[l]][cur_off[l]];
        pend_q <= left;
        cnt_q  <= cnt_run;
        if (left == '0) begin
          stall    <= 1'b0;
          done     <= 1'b1;
          pass_cnt <= cnt_run;
        end else begin
          stall <= 1'b1;
        end
      end else if (accept) begin
        done     <= 1'b1;
        pass_cnt <= '0;
      end
    end
  end

  always_comb
    for (int l = 0; l < LANES; l++) rd_data[l*DW +: DW] = rd_q[l];

  assert_done_ends_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !stall) else $error("done while stalled");

  assert_stall_resolves_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (stall || done)) else $error("stall dropped without done");

  assert_pend_shrinks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && $past(stall)) |-> ($countones(pend_q) < $past($countones(pend_q))))
    else $error("pass served no lane");

  assert_pass_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pass_cnt <= CW'(LANES))) else $error("pass count out of range");

  assert_single_lane_one_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && req_valid && $countones(lane_en) == 1) |=> (done && pass_cnt == CW'(1)))
    else $error("single lane took more than one pass");

  assert_empty_request_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && req_valid && lane_en == '0) |=> (done && pass_cnt == '0))
    else $error("empty request mishandled");
endmodule

// File: tb/xor_scratchpad_tb.sv
module xor_scratchpad_tb;
  localparam int L  = 32;
  localparam int AW = 13;
  localparam int DW = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_swz = 1'b0;
  logic [L-1:0] lane_en = '0;
  logic [L*AW-1:0] lane_addr = '0;
  logic [L*DW-1:0] lane_wdata = '0;
  logic stall, done;
  logic [L*DW-1:0] rd_data;
  logic [5:0] pass_cnt;

  int n_chk = 0, n_fail = 0;
  logic [AW-1:0] a [L];
  logic [DW-1:0] d [L];

  always #5 clk = ~clk;

  xor_scratchpad u_dut (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_swz(req_swz), .lane_en(lane_en), .lane_addr(lane_addr), .lane_wdata(lane_wdata),
    .stall(stall), .done(done), .rd_data(rd_data), .pass_cnt(pass_cnt));

  function automatic logic [AW-1:0] ad(input int row, input int wrd);
    return {row[5:0], wrd[4:0], 2'b00};
  endfunction
  function automatic logic [DW-1:0] lin(input int r, input int w);
    return 32'hA000_0000 | (r << 8) | w;
  endfunction
  function automatic logic [DW-1:0] swd(input int r, input int w);
    return 32'hB000_0000 | (r << 8) | w;
  endfunction
  function automatic logic [DW-1:0] rd(input int l);
    return rd_data[l*DW +: DW];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(input logic wr, input logic swz, input logic [L-1:0] en, output int cyc);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_swz = swz; lane_en = en;
    for (int l = 0; l < L; l++) begin
      lane_addr[l*AW +: AW] = a[l];
      lane_wdata[l*DW +: DW] = d[l];
    end
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 1;
    while (!done && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic t_reset;
    chk(!stall && !done && pass_cnt == 0, "R11 reset", {stall, done, pass_cnt}, 0);
  endtask

  task automatic t_tiles;
    int c;
    bit ok;
    for (int r = 0; r < 32; r++) begin
      for (int l = 0; l < L; l++) begin a[l] = ad(r, l); d[l] = lin(r, l); end
      run(1, 0, '1, c);
      if (r == 0) chk(pass_cnt == 1 && c == 1, "R2 linear row write", pass_cnt, 1);
    end
    for (int l = 0; l < L; l++) a[l] = ad(7, l);
    run(0, 0, '1, c);
    ok = 1;
    for (int l = 0; l < L; l++) if (rd(l) !== lin(7, l)) ok = 0;
    chk(ok && c == 1, "R2 linear row read", rd(3), lin(7, 3));
    for (int l = 0; l < L; l++) a[l] = ad(l, 5);
    run(0, 0, '1, c);
    chk(pass_cnt == 32 && c == 32, "R5 linear column passes", pass_cnt, 32);
    ok = 1;
    for (int l = 0; l < L; l++) if (rd(l) !== lin(l, 5)) ok = 0;
    chk(ok, "R6 linear column data", rd(9), lin(9, 5));
  endtask

  task automatic t_swizzle;
    int c;
    bit ok;
    for (int r = 0; r < 32; r++) begin
      for (int l = 0; l < L; l++) begin a[l] = ad(r, l); d[l] = swd(r, l); end
      run(1, 1, '1, c);
      if (r == 5) chk(pass_cnt == 1, "R5 swizzled row write", pass_cnt, 1);
    end
    for (int l = 0; l < L; l++) a[l] = ad(l, 5);
    run(0, 1, '1, c);
    chk(pass_cnt == 1 && c == 1, "R5 swizzled column passes", pass_cnt, 1);
    ok = 1;
    for (int l = 0; l < L; l++) if (rd(l) !== swd(l, 5)) ok = 0;
    chk(ok, "R6 swizzled column data", rd(17), swd(17, 5));
    for (int l = 0; l < L; l++) a[l] = ad(l, 5 ^ l);
    run(0, 0, '1, c);
    ok = 1;
    for (int l = 0; l < L; l++) if (rd(l) !== swd(l, 5)) ok = 0;
    chk(ok, "R5 physical layout", rd(6), swd(6, 5));
  endtask

  task automatic t_mapping;
    int c;
    a[0] = ad(0, 0); a[1] = ad(1, 0);
    run(0, 0, 32'h3, c);
    chk(pass_cnt == 2, "R1 128-byte stride same bank", pass_cnt, 2);
    a[1] = ad(0, 1);
    run(0, 0, 32'h3, c);
    chk(pass_cnt == 1, "R1 4-byte stride next bank", pass_cnt, 1);
    for (int l = 0; l < L; l++) a[l] = ad(l < 4 ? l : 0, l < 4 ? 0 : 1);
    run(0, 0, '1, c);
    chk(pass_cnt == 4 && c == 4, "R3 max distinct words", pass_cnt, 4);
    chk(rd(2) === swd(2, 2) && rd(20) === swd(0, 1), "R3 mixed data", rd(2), swd(2, 2));
  endtask

  task automatic t_broadcast;
    int c;
    bit ok;
    for (int l = 0; l < L; l++) a[l] = ad(4, 9);
    run(0, 0, '1, c);
    ok = 1;
    for (int l = 0; l < L; l++) if (rd(l) !== swd(4, 9 ^ 4)) ok = 0;
    chk(pass_cnt == 1 && ok, "R4 broadcast", rd(31), swd(4, 13));
  endtask

  task automatic t_partial;
    int c;
    for (int l = 0; l < L; l++) a[l] = ad(2, l);
    run(0, 1, 32'h0000_FFFF, c);
    chk(rd(3) === swd(2, 3), "R8 enabled lane data", rd(3), swd(2, 3));
    chk(rd(20) === 32'h0, "R8 disabled lane zero", rd(20), 0);
  endtask

  task automatic t_collision;
    int c;
    for (int l = 0; l < L; l++) begin a[l] = ad(40, 3); d[l] = 32'hC000 + l; end
    run(1, 0, 32'h0000_0088, c);
    run(0, 0, 32'h1, c);
    chk(rd(0) === 32'hC003, "R9 lowest lane wins", rd(0), 32'hC003);
  endtask

  task automatic t_empty;
    int c;
    run(0, 0, '0, c);
    chk(c == 1 && pass_cnt == 0, "R10 empty request", pass_cnt, 0);
  endtask

  task automatic t_stall;
    int c;
    for (int l = 0; l < L; l++) a[l] = ad(l, 5);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_swz = 1'b0; lane_en = '1;
    for (int l = 0; l < L; l++) lane_addr[l*AW +: AW] = a[l];
    @(negedge clk);
    chk(stall === 1'b1, "R7 stall raised", stall, 1);
    req_write = 1'b1; lane_en = 32'h1;
    lane_addr[0 +: AW] = ad(40, 3); lane_wdata[0 +: DW] = 32'hDEAD;
    repeat (3) @(negedge clk);
    req_valid = 1'b0;
    c = 4;
    while (!done && c < 100) begin @(negedge clk); c++; end
    chk(pass_cnt == 32 && c == 32, "R7 stall length", c, 32);
    a[0] = ad(40, 3);
    run(0, 0, 32'h1, c);
    chk(rd(0) === 32'hC003, "R7 held-off write ignored", rd(0), 32'hC003);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_tiles();
    t_swizzle();
    t_mapping();
    t_broadcast();
    t_partial();
    t_collision();
    t_empty();
    t_stall();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule